// File: doc/BRIEF.md
# System Clock Source Selector

This block decides which oscillator feeds the system clock. A 2-bit select field, written by software, picks between the primary oscillator, a low-frequency secondary oscillator and the internal oscillator block. A fail-safe monitor overrides that choice. When the fail-safe function is enabled and the source in use loses its valid indication, the block falls back to the internal low-frequency RC source. A separate internal-frequency field tracks the postscaler setting of the internal block.

The choice is presented as a registered 2-bit source code in one reference clock domain. A downstream glitch-free multiplexer is expected to act on it. A one-cycle switch strobe marks every change of the effective clock.

Two-speed start-up is supported. After reset, or on wake from sleep, with the primary configured as a crystal, the block runs from the low-frequency RC source until the primary reports valid.

Top module: `sysclk_source_sel`

## Requirements
- R1: After reset with two-speed start-up off, `src_o` is 0 (primary), `fs_active_o` is 0, `switch_o` is 0 and `int_freq_o` is 0, and no strobe appears in the following cycles.
- R2: Source codes are 0 primary, 1 secondary, 2 internal block, 3 internal low-frequency RC. Writing select value 00 gives 0, 01 gives 1, and both 10 and 11 give 2. `src_o` reflects a write at the clock edge that samples `sel_wr_i`.
- R3: Writing the select field with the value it already holds changes nothing and produces no strobe.
- R4: With `fs_en_i` high, a low `pri_ok_i` while `src_o` is 0 makes `src_o` 3 and `fs_active_o` 1 at the next edge.
- R5: With `fs_en_i` high, a low `sec_ok_i` while `src_o` is 1 makes `src_o` 3 and `fs_active_o` 1 at the next edge.
- R6: With `fs_en_i` low, a failing primary or secondary causes no fallback.
- R7: `fs_active_o` stays set when the failed source recovers, and also after a write of the unchanged select value. Only a write of a different select value or a reset clears it; that write takes effect at once.
- R8: A write to the internal-frequency field with a new value updates `int_freq_o` at the next edge. It pulses `switch_o` only when the effective source is 2.
- R9: When reset is released with `two_speed_en_i` and `pri_xtal_i` high, `src_o` becomes 3 with a strobe. It returns to 0, again with a strobe, at the edge that samples `pri_ok_i` high.
- R10: A falling `sleep_i` with select 00 and two-speed start-up on a crystal primary gives the same RC-then-primary sequence as R9.
- R11: `switch_o` is high for exactly the cycle in which `src_o` has just changed (or R8 applies). It is low in all other cycles.
- R12: While the source is 2, the primary and secondary valid inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_wr_i | input | 1 | Write strobe for the select field |
| sel_wdata_i | input | 2 | New select value |
| ifreq_wr_i | input | 1 | Write strobe for the internal-frequency field |
| ifreq_wdata_i | input | IFW | New internal-frequency value |
| fs_en_i | input | 1 | Fail-safe monitoring enable |
| pri_ok_i | input | 1 | Primary oscillator valid |
| sec_ok_i | input | 1 | Secondary oscillator valid |
| two_speed_en_i | input | 1 | Two-speed start-up enable |
| pri_xtal_i | input | 1 | Primary is configured as a crystal mode |
| sleep_i | input | 1 | High while the system sleeps; a fall is a wake |
| src_o | output | 2 | Effective clock source code |
| int_freq_o | output | IFW | Current internal-frequency setting |
| fs_active_o | output | 1 | Fail-safe fallback in force |
| switch_o | output | 1 | One-cycle strobe on a clock change |

## Verification
The assertions hold on every cycle for these behaviours:
- the fail-safe flag always forces code 3;
- a failure of the primary or secondary in use trips the fallback one edge later;
- the internal block source is immune to the oscillator valid inputs;
- every change of the source code is accompanied by the strobe.

Some behaviours depend on history and can only be shown by the bench's scenarios:
- the stickiness of the flag through source recovery and through same-value writes;
- the select sweep over all sixteen old/new pairs;
- the frequency-field strobe depending on the source;
- the two-speed sequences after reset and on wake.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    typedef enum logic [1:0] {
        SRC_PRI  = 2'd0,
        SRC_SEC  = 2'd1,
        SRC_INT  = 2'd2,
        SRC_LFRC = 2'd3
    } src_e;
endpackage

// File: rtl/sysclk_fail_mon.sv
module sysclk_fail_mon
    import sysclk_pkg::*;
(
    input  logic armed_i,
    input  logic fs_en_i,
    input  src_e cur_i,
    input  logic pri_ok_i,
    input  logic sec_ok_i,
    output logic trip_o
);
    logic pri_bad, sec_bad;

    always_comb begin
        pri_bad = (cur_i == SRC_PRI) && !pri_ok_i;
        sec_bad = (cur_i == SRC_SEC) && !sec_ok_i;
        trip_o  = armed_i && fs_en_i && (pri_bad || sec_bad);
    end
endmodule

// File: rtl/sysclk_src_map.sv
module sysclk_src_map
    import sysclk_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       fs_i,
    input  logic       ts_i,
    output src_e       src_o
);
    always_comb begin
        if (fs_i || ts_i) begin
            src_o = SRC_LFRC;
        end else begin
            unique case (sel_i)
                2'b00:   src_o = SRC_PRI;
                2'b01:   src_o = SRC_SEC;
                default: src_o = SRC_INT;
            endcase
        end
    end
endmodule

// File: rtl/sysclk_source_sel.sv
module sysclk_source_sel
    import sysclk_pkg::*;
#(
    parameter int IFW = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           sel_wr_i,
    input  logic [1:0]     sel_wdata_i,
    input  logic           ifreq_wr_i,
    input  logic [IFW-1:0] ifreq_wdata_i,
    input  logic           fs_en_i,
    input  logic           pri_ok_i,
    input  logic           sec_ok_i,
    input  logic           two_speed_en_i,
    input  logic           pri_xtal_i,
    input  logic           sleep_i,
    output logic [1:0]     src_o,
    output logic [IFW-1:0] int_freq_o,
    output logic           fs_active_o,
    output logic           switch_o
);
    typedef struct packed {
        logic [1:0]     sel;
        logic [IFW-1:0] ifreq;
        logic           fs;
        logic           ts;
        logic           start;
        logic           slp;
        src_e           src;
        logic           sw;
    } state_t;

    state_t st_d, st_q, nx;
    logic   trip, ifreq_chg, ts_allowed;
    src_e   src_next;

    sysclk_fail_mon i_fail_mon (
        .armed_i (!st_q.start),
        .fs_en_i (fs_en_i),
        .cur_i   (st_q.src),
        .pri_ok_i(pri_ok_i),
        .sec_ok_i(sec_ok_i),
        .trip_o  (trip)
    );

    always_comb begin
        nx         = st_q;
        nx.start   = 1'b0;
        nx.slp     = sleep_i;
        ts_allowed = two_speed_en_i && pri_xtal_i;
        ifreq_chg  = ifreq_wr_i && (ifreq_wdata_i != st_q.ifreq);

        if (trip) nx.fs = 1'b1;
        if (st_q.ts && pri_ok_i) nx.ts = 1'b0;
        if (st_q.start && ts_allowed) nx.ts = 1'b1;
        if (st_q.slp && !sleep_i && ts_allowed && st_q.sel == 2'b00) nx.ts = 1'b1;

        if (sel_wr_i && (sel_wdata_i != st_q.sel)) begin
            nx.sel = sel_wdata_i;
            nx.fs  = 1'b0;
            nx.ts  = 1'b0;
        end
        if (ifreq_chg) nx.ifreq = ifreq_wdata_i;
    end

    sysclk_src_map i_src_map (
        .sel_i(nx.sel),
        .fs_i (nx.fs),
        .ts_i (nx.ts),
        .src_o(src_next)
    );

    always_comb begin
        st_d     = nx;
        st_d.src = src_next;
        st_d.sw  = (src_next != st_q.src) || (ifreq_chg && src_next == SRC_INT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
            st_q.src   <= SRC_PRI;
        end else begin
            st_q <= st_d;
        end
    end

    assign src_o       = st_q.src;
    assign int_freq_o  = st_q.ifreq;
    assign fs_active_o = st_q.fs;
    assign switch_o    = st_q.sw;
endmodule

// File: rtl/sysclk_source_sel_chk.sv
module sysclk_source_sel_chk #(
    parameter int IFW = 3
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           sel_wr_i,
    input logic           fs_en_i,
    input logic           pri_ok_i,
    input logic           sec_ok_i,
    input logic [1:0]     src_o,
    input logic [IFW-1:0] int_freq_o,
    input logic           fs_active_o,
    input logic           switch_o
);
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    p_fs_forces_rc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fs_active_o |-> src_o == 2'd3);

    p_pri_trip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
        (fs_en_i && src_o == 2'd0 && !pri_ok_i && !sel_wr_i)
        |=> (src_o == 2'd3 && fs_active_o));

    p_sec_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
        (fs_en_i && src_o == 2'd1 && !sec_ok_i && !sel_wr_i)
        |=> (src_o == 2'd3 && fs_active_o));

    p_int_immune_r12: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
        (src_o == 2'd2 && !sel_wr_i) |=> src_o == 2'd2);

    p_change_strobes_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen_q)
        !$stable(src_o) |-> switch_o);
endmodule

bind sysclk_source_sel sysclk_source_sel_chk #(.IFW(IFW)) i_chk (.*);

// File: tb/test_sysclk_source_sel.sv
module test_sysclk_source_sel;
    localparam int IFW    = 3;
    localparam int PERIOD = 10;

    logic           clk_i = 1'b0;
    logic           rst_ni = 1'b0;
    logic           sel_wr_i = 1'b0;
    logic [1:0]     sel_wdata_i = '0;
    logic           ifreq_wr_i = 1'b0;
    logic [IFW-1:0] ifreq_wdata_i = '0;
    logic           fs_en_i = 1'b1;
    logic           pri_ok_i = 1'b1;
    logic           sec_ok_i = 1'b1;
    logic           two_speed_en_i = 1'b0;
    logic           pri_xtal_i = 1'b0;
    logic           sleep_i = 1'b0;
    logic [1:0]     src_o;
    logic [IFW-1:0] int_freq_o;
    logic           fs_active_o;
    logic           switch_o;

    int n_chk = 0;
    int n_bad = 0;
    int cur_src = 0;
    int cur_freq = 0;

    sysclk_source_sel #(.IFW(IFW)) i_sysclk_source_sel (.*);

    always #(PERIOD/2) clk_i = ~clk_i;

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int map_sel(int v);
        return (v == 0) ? 0 : (v == 1) ? 1 : 2;
    endfunction

    task automatic wr_sel(int v);
        sel_wr_i    = 1'b1;
        sel_wdata_i = 2'(v);
        step();
        sel_wr_i = 1'b0;
    endtask

    task automatic wr_freq(int v);
        ifreq_wr_i    = 1'b1;
        ifreq_wdata_i = IFW'(v);
        step();
        ifreq_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        step();
        rst_ni = 1'b1;
    endtask

    initial begin
        #(PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        rst_ni = 1'b1;
        // R1 reset state and quiet cycles
        for (int i = 0; i < 4; i++) begin
            chk("R1 src", src_o, 0);
            chk("R1 fs", fs_active_o, 0);
            chk("R1 sw", switch_o, 0);
            chk("R1 freq", int_freq_o, 0);
            step();
        end

        // R2 R3 R11: every old/new select pair
        cur_src = 0;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr_sel(a);
                cur_src = map_sel(a);
                step();
                wr_sel(b);
                chk("R2 src", src_o, map_sel(b));
                chk("R3/R11 sw", switch_o, (map_sel(b) != cur_src) ? 1 : 0);
                cur_src = map_sel(b);
                step();
                chk("R11 sw low", switch_o, 0);
            end
        end

        // R8 frequency field on internal block
        wr_sel(2);
        step();
        cur_freq = int_freq_o;
        for (int v = 0; v < (1 << IFW); v++) begin
            wr_freq((v * 3) % (1 << IFW));
            chk("R8 freq", int_freq_o, (v * 3) % (1 << IFW));
            chk("R8 sw int", switch_o, (((v * 3) % (1 << IFW)) != cur_freq) ? 1 : 0);
            cur_freq = (v * 3) % (1 << IFW);
        end
        wr_sel(0);
        step();
        wr_freq((cur_freq + 1) % (1 << IFW));
        chk("R8 freq pri", int_freq_o, (cur_freq + 1) % (1 << IFW));
        chk("R8 no sw pri", switch_o, 0);

        // R4 primary failure, R7 stickiness
        pri_ok_i = 1'b0;
        step();
        chk("R4 src", src_o, 3);
        chk("R4 fs", fs_active_o, 1);
        chk("R11 sw", switch_o, 1);
        step();
        chk("R11 sw once", switch_o, 0);
        pri_ok_i = 1'b1;
        step();
        step();
        chk("R7 recover src", src_o, 3);
        chk("R7 recover fs", fs_active_o, 1);
        wr_sel(0);
        step();
        chk("R7 same write", fs_active_o, 1);
        chk("R3 same write src", src_o, 3);
        wr_sel(1);
        chk("R7 clear fs", fs_active_o, 0);
        chk("R7 new src", src_o, 1);
        chk("R7 sw", switch_o, 1);

        // R5 secondary failure
        step();
        sec_ok_i = 1'b0;
        step();
        chk("R5 src", src_o, 3);
        chk("R5 fs", fs_active_o, 1);
        sec_ok_i = 1'b1;
        wr_sel(2);
        chk("R5 leave fs", fs_active_o, 0);

        // R12 internal block ignores oscillator status
        pri_ok_i = 1'b0;
        sec_ok_i = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R12 src", src_o, 2);
            chk("R12 fs", fs_active_o, 0);
            chk("R12 sw", switch_o, 0);
        end
        pri_ok_i = 1'b1;
        sec_ok_i = 1'b1;

        // R6 fail-safe disabled
        fs_en_i = 1'b0;
        wr_sel(0);
        step();
        pri_ok_i = 1'b0;
        step();
        step();
        chk("R6 pri src", src_o, 0);
        chk("R6 pri fs", fs_active_o, 0);
        pri_ok_i = 1'b1;
        wr_sel(1);
        step();
        sec_ok_i = 1'b0;
        step();
        step();
        chk("R6 sec src", src_o, 1);
        chk("R6 sec fs", fs_active_o, 0);
        sec_ok_i = 1'b1;

        // R9 two-speed after reset
        fs_en_i        = 1'b1;
        two_speed_en_i = 1'b1;
        pri_xtal_i     = 1'b1;
        pri_ok_i       = 1'b0;
        do_reset();
        step();
        chk("R9 rc", src_o, 3);
        chk("R9 sw", switch_o, 1);
        chk("R9 fs", fs_active_o, 0);
        step();
        step();
        chk("R9 hold rc", src_o, 3);
        pri_ok_i = 1'b1;
        step();
        chk("R9 pri", src_o, 0);
        chk("R9 sw back", switch_o, 1);

        // R1 reset without crystal: no switch
        pri_xtal_i = 1'b0;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1 no sw", switch_o, 0);
            chk("R1 src", src_o, 0);
        end

        // R10 wake with two-speed
        pri_xtal_i = 1'b1;
        fs_en_i    = 1'b0;
        sleep_i    = 1'b1;
        step();
        step();
        pri_ok_i = 1'b0;
        sleep_i  = 1'b0;
        step();
        chk("R10 rc", src_o, 3);
        chk("R10 sw", switch_o, 1);
        step();
        chk("R10 hold", src_o, 3);
        pri_ok_i = 1'b1;
        step();
        chk("R10 pri", src_o, 0);
        chk("R10 sw back", switch_o, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule